// File: doc/BRIEF.md
# Dual-Channel Atomic DAC Code Latch

This block sits between a byte-wide host write port and two 12-bit digital-to-analog converters. The host places each channel's 12-bit code with two byte writes. The first byte goes to a per-channel staging register and changes nothing at the converter. The second write carries the top four bits. On that write, the staged byte and the new nibble are joined and loaded into the channel's output latch in a single clock edge. The converter therefore never sees a half-updated code.

The commit always takes whatever byte is in staging at that moment. If the host writes the nibble without first writing a new low byte, the older staged byte is used. Each commit also raises a one-cycle update strobe for that channel.

An external comparator on the upper address bits drives a base-select input. The block decodes only the low three address bits. Offsets 4 and 5 serve channel A (low byte, then upper nibble). Offsets 6 and 7 serve channel B in the same way.

Top module: `dac_pair_latch`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `code_a` and `code_b` are 0 and `upd_a` and `upd_b` are 0.
- R2: A write at offset 4 (3'b100) loads `wr_data` into channel A's staging register only. `code_a` does not change.
- R3: A write at offset 5 (3'b101) sets `code_a` after that clock edge. `code_a[11:8]` takes `wr_data[3:0]` and `code_a[7:0]` takes channel A's staged byte. `wr_data[7:4]` has no effect.
- R4: Offsets 6 (3'b110) and 7 (3'b111) do the same for channel B, staging into B and committing `code_b`.
- R5: `upd_a` (or `upd_b`) is high for exactly the one cycle after the edge that sampled that channel's upper-nibble write, and low otherwise.
- R6: An upper-nibble write with no new low byte since the last commit reuses the previously staged byte. A low-byte write after a commit leaves the code unchanged until the next upper-nibble write.
- R7: A write is taken only on a rising edge with both `wr_en` and `base_hit` high. Offsets 0 to 3, or a low `wr_en` or `base_hit`, change no staging, no code and no strobe.
- R8: A write to one channel never changes the other channel's staging, code or strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, sampled each rising edge |
| base_hit | input | 1 | High when the upper address bits match the block's base |
| addr_lo | input | 3 | Offset from the base |
| wr_data | input | 8 | Write byte |
| code_a | output | 12 | Channel A code to the converter |
| code_b | output | 12 | Channel B code to the converter |
| upd_a | output | 1 | One-cycle pulse after a channel A commit |
| upd_b | output | 1 | One-cycle pulse after a channel B commit |

## Verification
A staging register holding the wrong byte stays hidden until the next upper-nibble write to that channel. It then shows as a wrong low byte on the code one cycle after that write. The bench therefore commits many times after varied low-byte histories, including commits with no new low byte. A decode or isolation fault shows one cycle after the offending write, as a code change or strobe where none belongs. A per-cycle model comparison catches this at the first such edge.

// File: rtl/dac_latch_pkg.sv
package dac_latch_pkg;
    localparam int unsigned DAC_CH_N   = 2;
    localparam int unsigned FIRST_OFS  = 4;

    function automatic int unsigned lo_offset(input int unsigned ch);
        return FIRST_OFS + 2 * ch;
    endfunction

    function automatic int unsigned hi_offset(input int unsigned ch);
        return FIRST_OFS + 2 * ch + 1;
    endfunction
endpackage

// File: rtl/dac_wr_decode.sv
module dac_wr_decode
    import dac_latch_pkg::*;
#(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned N_CH   = DAC_CH_N
) (
    input  logic              wr_en,
    input  logic              base_hit,
    input  logic [ADDR_W-1:0] addr_lo,
    output logic [N_CH-1:0]   lo_we,
    output logic [N_CH-1:0]   hi_we
);
    logic take;

    always_comb begin
        take = wr_en && base_hit;
        for (int unsigned ch = 0; ch < N_CH; ch++) begin
            lo_we[ch] = take && (addr_lo == ADDR_W'(lo_offset(ch)));
            hi_we[ch] = take && (addr_lo == ADDR_W'(hi_offset(ch)));
        end
    end

    // R8: at most one staging or commit enable per write
    always_comb begin
        assert_one_target_R8: assert ($onehot0({lo_we, hi_we}));
    end
endmodule

// File: rtl/dac_chan_latch.sv
module dac_chan_latch #(
    parameter int unsigned CODE_W = 12,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [CODE_W-1:0] code,
    output logic              upd
);
    localparam int unsigned NIB_W = CODE_W - BYTE_W;

    typedef struct packed {
        logic [BYTE_W-1:0] stage;
        logic [CODE_W-1:0] code;
        logic              upd;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        if (lo_we) begin
            st_d.stage = wr_data;
        end
        if (hi_we) begin
            st_d.code = {wr_data[NIB_W-1:0], st_q.stage};
            st_d.upd  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code = st_q.code;
    assign upd  = st_q.upd;

    assert_code_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_we |=> $stable(code));

    assert_nibble_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hi_we |=> code[CODE_W-1:BYTE_W] == $past(wr_data[NIB_W-1:0]));

    assert_low_from_stage_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hi_we |=> code[BYTE_W-1:0] == $past(st_q.stage));

    assert_strobe_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        upd |-> $past(hi_we));
endmodule

// File: rtl/dac_pair_latch.sv
module dac_pair_latch
    import dac_latch_pkg::*;
#(
    parameter int unsigned CODE_W = 12,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              base_hit,
    input  logic [ADDR_W-1:0] addr_lo,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b,
    output logic              upd_a,
    output logic              upd_b
);
    localparam int unsigned N_CH = DAC_CH_N;

    logic [N_CH-1:0]   lo_we, hi_we;
    logic [N_CH-1:0]   upd_v;
    logic [CODE_W-1:0] code_v [N_CH];

    dac_wr_decode #(.ADDR_W(ADDR_W), .N_CH(N_CH)) u_dec (
        .wr_en    (wr_en),
        .base_hit (base_hit),
        .addr_lo  (addr_lo),
        .lo_we    (lo_we),
        .hi_we    (hi_we)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        dac_chan_latch #(.CODE_W(CODE_W), .BYTE_W(BYTE_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .lo_we   (lo_we[ch]),
            .hi_we   (hi_we[ch]),
            .wr_data (wr_data),
            .code    (code_v[ch]),
            .upd     (upd_v[ch])
        );
    end

    assign code_a = code_v[0];
    assign code_b = code_v[1];
    assign upd_a  = upd_v[0];
    assign upd_b  = upd_v[1];

    assert_idle_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && base_hit) |=> !upd_a && !upd_b);

    assert_idle_codes_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && base_hit) |=> $stable(code_a) && $stable(code_b));

    assert_single_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_a && upd_b));
endmodule

// File: tb/tb_dac_pair_latch.sv
`timescale 1ns/1ps
module tb_dac_pair_latch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        base_hit = 1'b0;
    logic [2:0]  addr_lo = '0;
    logic [7:0]  wr_data = '0;
    logic [11:0] code_a, code_b;
    logic        upd_a, upd_b;

    int checks = 0;
    int errors = 0;

    // behavioural reference
    int m_stage [2];
    int m_code  [2];
    int m_upd   [2];

    always #2.5 clk = ~clk;

    dac_pair_latch dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .base_hit(base_hit),
        .addr_lo(addr_lo), .wr_data(wr_data),
        .code_a(code_a), .code_b(code_b), .upd_a(upd_a), .upd_b(upd_b)
    );

    always @(posedge clk) begin
        m_upd[0] = 0;
        m_upd[1] = 0;
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_stage[c] = 0;
                m_code[c]  = 0;
            end
        end else if (wr_en && base_hit) begin
            case (addr_lo)
                3'd4: m_stage[0] = wr_data;
                3'd5: begin m_code[0] = (wr_data % 16) * 256 + m_stage[0]; m_upd[0] = 1; end
                3'd6: m_stage[1] = wr_data;
                3'd7: begin m_code[1] = (wr_data % 16) * 256 + m_stage[1]; m_upd[1] = 1; end
                default: ;
            endcase
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the rising edge
    bit cmp_on = 1'b0;
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(code_a == m_code[0][11:0], "R3 code_a vs model", code_a, m_code[0]);
            chk(code_b == m_code[1][11:0], "R4 code_b vs model", code_b, m_code[1]);
            chk(upd_a == m_upd[0][0], "R5 upd_a vs model", upd_a, m_upd[0]);
            chk(upd_b == m_upd[1][0], "R5 upd_b vs model", upd_b, m_upd[1]);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d,
                      input logic en = 1'b1, input logic hit = 1'b1);
        @(negedge clk);
        wr_en = en; base_hit = hit; addr_lo = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; base_hit = 1'b0;
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        chk(code_a == 0 && code_b == 0, "R1 codes in reset", {code_a, code_b}, 0);
        chk(!upd_a && !upd_b, "R1 strobes in reset", {upd_a, upd_b}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(code_a == 0 && code_b == 0 && !upd_a && !upd_b, "R1 after reset", code_a, 0);
        cmp_on = 1'b1;

        wr(3'd4, 8'hAB);
        chk(code_a == 12'h000, "R2 low byte leaves code", code_a, 12'h000);
        chk(!upd_a, "R2 no strobe on low byte", upd_a, 0);
        wr(3'd5, 8'hF3);
        chk(code_a == 12'h3AB, "R3 commit ignores data[7:4]", code_a, 12'h3AB);
        chk(upd_a && !upd_b, "R5 strobe after commit", {upd_a, upd_b}, 2);
        @(negedge clk);
        chk(!upd_a, "R5 strobe lasts one cycle", upd_a, 0);

        wr(3'd5, 8'h05);
        chk(code_a == 12'h5AB, "R6 stale byte reused", code_a, 12'h5AB);
        wr(3'd4, 8'h11);
        chk(code_a == 12'h5AB, "R6 new low byte not visible", code_a, 12'h5AB);

        wr(3'd5, 8'h0E, 1'b1, 1'b0);
        chk(code_a == 12'h5AB && !upd_a, "R7 base_hit low ignored", code_a, 12'h5AB);
        wr(3'd5, 8'h0E, 1'b0, 1'b1);
        chk(code_a == 12'h5AB && !upd_a, "R7 wr_en low ignored", code_a, 12'h5AB);
        for (int a = 0; a < 4; a++) begin
            wr(3'(a), 8'hC7);
            chk(code_a == 12'h5AB && code_b == 0 && !upd_a && !upd_b,
                "R7 offset below 4 ignored", code_a, 12'h5AB);
        end
        wr(3'd5, 8'h02);
        chk(code_a == 12'h211, "R7 staging untouched by ignored writes", code_a, 12'h211);

        wr(3'd6, 8'h5C);
        chk(code_b == 0 && code_a == 12'h211, "R8 B staging isolated", code_b, 0);
        wr(3'd7, 8'h19);
        chk(code_b == 12'h95C, "R4 B commit", code_b, 12'h95C);
        chk(upd_b && !upd_a, "R8 only B strobes", {upd_a, upd_b}, 1);
        chk(code_a == 12'h211, "R8 A code untouched", code_a, 12'h211);
        wr(3'd5, 8'h07);
        chk(code_a == 12'h711, "R8 A staging untouched by B", code_a, 12'h711);

        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            wr_en    = lfsr[0] | lfsr[1];
            base_hit = lfsr[2] | lfsr[3] | lfsr[4];
            addr_lo  = lfsr[7:5];
            wr_data  = lfsr[15:8];
        end
        @(negedge clk);
        wr_en = 1'b0;
        repeat (3) @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule